// File: doc/BRIEF.md
# Bunch-Crossing Trigger Tagging Unit

The unit runs on the 40 MHz bunch-crossing clock and labels every level-1 accept with the crossing and event it belongs to. It has two counters. A 12-bit crossing counter is zeroed by a once-per-orbit strobe and otherwise wraps after a fixed orbit length. A 24-bit event counter is zeroed by an event-counter-reset strobe. On each accept, the current crossing number, event number and the 8-bit trigger type are packed into a record. The record is pushed into one queue per processing lane.

Each lane pops its queue head when a front-end data header arrives. It compares the header's crossing number with the queued one, and on a difference (or when a header arrives with nothing queued) it sets a sticky error bit. A clear strobe resets that bit. A busy output paces the trigger source as the queues fill. An accept that finds a queue full is dropped for every lane and counted.

Top module: `bx_tag_unit`

## Requirements
- R1: An orbit strobe sampled at a clock edge makes the crossing counter 0 after that edge. The counter then rises by 1 at each following edge.
- R2: With no orbit strobe, the crossing counter goes from ORBIT_LEN-1 (default 3564, so 3563) to 0.
- R3: An accept stores the crossing counter value of the accept cycle, together with ttype_i. The record is at the head of every lane's queue one cycle later (rec_valid_o set).
- R4: An event-counter-reset strobe clears the event counter. An accept in the same cycle as that strobe carries event number 0. Every accept, dropped or not, advances the event counter by one.
- R5: Each lane hands out its records in accept order. It removes the head when hdr_valid_i for that lane is high.
- R6: busy_o is high whenever any lane queue has two or fewer free entries. With the default depth of 8, that means six or more records held.
- R7: An accept that arrives while any lane queue is full enqueues nothing in any lane. It raises ovf_cnt_o by one, saturating.
- R8: A header whose crossing number differs from the lane's head record sets that lane's err_o bit one cycle later. The bit stays set afterwards.
- R9: A header that arrives while the lane's queue is empty also sets that lane's err_o bit.
- R10: err_clr_i for a lane clears its err_o bit one cycle later. A mismatch in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| orbit_rst_i | input | 1 | Once-per-orbit crossing counter reset strobe |
| ecr_i | input | 1 | Event counter reset strobe |
| l1a_i | input | 1 | Level-1 accept |
| ttype_i | input | 8 | Trigger type delivered with the accept |
| hdr_valid_i | input | NUM_LANES | Per-lane data header present |
| hdr_bcid_i | input | NUM_LANES*12 | Per-lane crossing number from the header |
| err_clr_i | input | NUM_LANES | Per-lane error clear strobe |
| rec_valid_o | output | NUM_LANES | Per-lane queue holds a record |
| rec_bcid_o | output | NUM_LANES*12 | Per-lane head record crossing number |
| rec_evid_o | output | NUM_LANES*24 | Per-lane head record event number |
| rec_ttype_o | output | NUM_LANES*8 | Per-lane head record trigger type |
| err_o | output | NUM_LANES | Per-lane sticky mismatch flag |
| busy_o | output | 1 | Trigger throttle |
| ovf_cnt_o | output | OVF_W | Count of dropped accepts |

## Verification
The properties assume that every strobe is clean for a whole cycle and that ORBIT_LEN fits the 12-bit counter. They also assume that header inputs are meaningful only in cycles where hdr_valid_i is high. The bench drives every input on the falling edge and holds it for exactly one rising edge. It reads expected crossing numbers from the count of edges since its own orbit strobe, and it empties the queues between scenarios so that each one starts from a known fill level.

// File: rtl/bxt_pkg.sv
package bxt_pkg;
  localparam int unsigned BCID_W  = 12;
  localparam int unsigned EVID_W  = 24;
  localparam int unsigned TTYPE_W = 8;

  typedef struct packed {
    logic [EVID_W-1:0]  evid;
    logic [BCID_W-1:0]  bcid;
    logic [TTYPE_W-1:0] ttype;
  } tag_rec_t;
endpackage

// File: rtl/bxt_counters.sv
module bxt_counters import bxt_pkg::*; #(
  parameter int unsigned ORBIT_LEN = 3564
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              orbit_rst_i,
  input  logic              ecr_i,
  input  logic              l1a_i,
  output logic [BCID_W-1:0] bcid_o,
  output logic [EVID_W-1:0] evid_o
);
  localparam logic [BCID_W-1:0] LAST_BC = BCID_W'(ORBIT_LEN - 1);

  logic [BCID_W-1:0] bcid_q;
  logic [EVID_W-1:0] evcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                bcid_q <= '0;
    else if (orbit_rst_i)       bcid_q <= '0;
    else if (bcid_q == LAST_BC) bcid_q <= '0;
    else                        bcid_q <= bcid_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    evcnt_q <= '0;
    else if (ecr_i) evcnt_q <= l1a_i ? EVID_W'(1) : '0;
    else if (l1a_i) evcnt_q <= evcnt_q + 1'b1;
  end

  assign bcid_o = bcid_q;
  assign evid_o = ecr_i ? '0 : evcnt_q;

  // R1
  orbit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    orbit_rst_i |=> bcid_q == '0);

  // R2
  bcid_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!orbit_rst_i && bcid_q == LAST_BC) |=> bcid_q == '0);

  // R4
  ecr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecr_i && !l1a_i) |=> evcnt_q == '0);
endmodule

// File: rtl/bxt_fifo.sv
module bxt_fifo import bxt_pkg::*; #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  tag_rec_t         din_i,
  input  logic             pop_i,
  output tag_rec_t         dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] level_o
);
  tag_rec_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= adv(wr_q);
      end
      if (do_pop) rd_q <= adv(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dout_o  = mem_q[rd_q];
  assign level_o = cnt_q;

  // R5
  fifo_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R5
  fifo_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/bxt_lane.sv
module bxt_lane import bxt_pkg::*; #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  tag_rec_t          rec_i,
  input  logic              hdr_valid_i,
  input  logic [BCID_W-1:0] hdr_bcid_i,
  input  logic              err_clr_i,
  output tag_rec_t          head_o,
  output logic              head_valid_o,
  output logic              full_o,
  output logic              busy_o,
  output logic              err_o
);
  logic             empty, mismatch, err_q;
  logic [CNT_W-1:0] level;

  bxt_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .din_i   (rec_i),
    .pop_i   (hdr_valid_i),
    .dout_o  (head_o),
    .empty_o (empty),
    .full_o  (full_o),
    .level_o (level)
  );

  // an unmatched header counts as a mismatch
  assign mismatch = hdr_valid_i && (empty || hdr_bcid_i != head_o.bcid);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (mismatch)  err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign head_valid_o = !empty;
  assign busy_o       = (level + CNT_W'(2) >= CNT_W'(DEPTH));
  assign err_o        = err_q;

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i) |=> err_q);

  // R9
  empty_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && !head_valid_o) |=> err_q);

  // R10
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !hdr_valid_i) |=> !err_q);
endmodule

// File: rtl/bx_tag_unit.sv
module bx_tag_unit import bxt_pkg::*; #(
  parameter int unsigned NUM_LANES  = 8,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned ORBIT_LEN  = 3564,
  parameter int unsigned OVF_W      = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          orbit_rst_i,
  input  logic                          ecr_i,
  input  logic                          l1a_i,
  input  logic [TTYPE_W-1:0]            ttype_i,
  input  logic [NUM_LANES-1:0]          hdr_valid_i,
  input  logic [NUM_LANES*BCID_W-1:0]   hdr_bcid_i,
  input  logic [NUM_LANES-1:0]          err_clr_i,
  output logic [NUM_LANES-1:0]          rec_valid_o,
  output logic [NUM_LANES*BCID_W-1:0]   rec_bcid_o,
  output logic [NUM_LANES*EVID_W-1:0]   rec_evid_o,
  output logic [NUM_LANES*TTYPE_W-1:0]  rec_ttype_o,
  output logic [NUM_LANES-1:0]          err_o,
  output logic                          busy_o,
  output logic [OVF_W-1:0]              ovf_cnt_o
);
  logic [BCID_W-1:0]    cur_bcid;
  logic [EVID_W-1:0]    cur_evid;
  logic [NUM_LANES-1:0] lane_full, lane_busy;
  logic                 any_full, push;
  logic [OVF_W-1:0]     ovf_q;
  tag_rec_t             new_rec;

  bxt_counters #(.ORBIT_LEN(ORBIT_LEN)) i_counters (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .orbit_rst_i (orbit_rst_i),
    .ecr_i       (ecr_i),
    .l1a_i       (l1a_i),
    .bcid_o      (cur_bcid),
    .evid_o      (cur_evid)
  );

  assign new_rec  = '{evid: cur_evid, bcid: cur_bcid, ttype: ttype_i};
  assign any_full = |lane_full;
  assign push     = l1a_i && !any_full;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    tag_rec_t head;

    bxt_lane #(.DEPTH(FIFO_DEPTH)) i_lane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_i       (push),
      .rec_i        (new_rec),
      .hdr_valid_i  (hdr_valid_i[l]),
      .hdr_bcid_i   (hdr_bcid_i[l*BCID_W +: BCID_W]),
      .err_clr_i    (err_clr_i[l]),
      .head_o       (head),
      .head_valid_o (rec_valid_o[l]),
      .full_o       (lane_full[l]),
      .busy_o       (lane_busy[l]),
      .err_o        (err_o[l])
    );

    assign rec_bcid_o[l*BCID_W +: BCID_W]    = head.bcid;
    assign rec_evid_o[l*EVID_W +: EVID_W]    = head.evid;
    assign rec_ttype_o[l*TTYPE_W +: TTYPE_W] = head.ttype;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ovf_q <= '0;
    else if (l1a_i && any_full && ovf_q != '1)     ovf_q <= ovf_q + 1'b1;
  end

  assign busy_o    = |lane_busy;
  assign ovf_cnt_o = ovf_q;

  // R6
  full_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_full |-> busy_o);

  // R7
  drop_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && any_full && ovf_q != '1) |=> ovf_q == $past(ovf_q) + 1'b1);

  // R7
  drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1a_i && any_full && hdr_valid_i == '0) |=> $stable(rec_valid_o));
endmodule

// File: tb/test_bx_tag_unit.sv
`timescale 1ns/1ps
module test_bx_tag_unit;
  localparam int CLK_PERIOD = 25;
  localparam int NL = 8;
  localparam int BW = 12;
  localparam int EW = 24;
  localparam int TW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic orbit = 1'b0, ecr = 1'b0, l1a = 1'b0;
  logic [TW-1:0]    ttype = '0;
  logic [NL-1:0]    hdr_valid = '0, err_clr = '0;
  logic [NL*BW-1:0] hdr_bcid = '0;
  logic [NL-1:0]    rec_valid, err;
  logic [NL*BW-1:0] rec_bcid;
  logic [NL*EW-1:0] rec_evid;
  logic [NL*TW-1:0] rec_ttype;
  logic             busy;
  logic [15:0]      ovf_cnt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bx_tag_unit i_bx_tag_unit (
    .clk_i(clk), .rst_ni(rst_n), .orbit_rst_i(orbit), .ecr_i(ecr), .l1a_i(l1a),
    .ttype_i(ttype), .hdr_valid_i(hdr_valid), .hdr_bcid_i(hdr_bcid),
    .err_clr_i(err_clr), .rec_valid_o(rec_valid), .rec_bcid_o(rec_bcid),
    .rec_evid_o(rec_evid), .rec_ttype_o(rec_ttype), .err_o(err),
    .busy_o(busy), .ovf_cnt_o(ovf_cnt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_orbit();
    orbit = 1'b1; tick(); orbit = 1'b0;
  endtask

  task automatic pulse_ecr();
    ecr = 1'b1; tick(); ecr = 1'b0;
  endtask

  task automatic accept(input logic [TW-1:0] tt);
    l1a = 1'b1; ttype = tt; tick(); l1a = 1'b0;
  endtask

  task automatic pop_lane(input int l, input logic [BW-1:0] b);
    hdr_valid = '0; hdr_valid[l] = 1'b1; hdr_bcid[l*BW +: BW] = b;
    tick();
    hdr_valid = '0;
  endtask

  task automatic drain();
    for (int k = 0; k < 2*DEPTH && |rec_valid; k++) begin
      hdr_valid = rec_valid; hdr_bcid = rec_bcid;
      tick();
    end
    hdr_valid = '0;
  endtask

  function automatic logic [BW-1:0] hb(input int l); return rec_bcid[l*BW +: BW]; endfunction
  function automatic logic [EW-1:0] he(input int l); return rec_evid[l*EW +: EW]; endfunction
  function automatic logic [TW-1:0] ht(input int l); return rec_ttype[l*TW +: TW]; endfunction

  task automatic t_reset();
    chk("reset rec_valid", rec_valid, 0);
    chk("reset busy", busy, 0);
    chk("reset err", err, 0);
    chk("reset ovf", ovf_cnt, 0);
  endtask

  task automatic t_bcid();
    pulse_orbit();
    wait_ticks(5);
    accept(8'hA5);
    chk("R3 all lanes valid", rec_valid, 8'hFF);
    for (int l = 0; l < NL; l++) begin
      chk("R3 captured bcid", hb(l), 5);
      chk("R3 ttype forwarded", ht(l), 8'hA5);
    end
    drain();
    wait_ticks(40);
    pulse_orbit();
    wait_ticks(2);
    accept(8'h11);
    chk("R1 bcid after mid-orbit strobe", hb(0), 2);
    drain();
    chk("R8 no error on matching headers", err, 0);
  endtask

  task automatic t_wrap();
    pulse_orbit();
    wait_ticks(3563);
    accept(8'h01);
    accept(8'h02);
    chk("R2 last bcid of orbit", hb(0), 3563);
    pop_lane(0, 12'd3563);
    chk("R2 bcid wrapped to zero", hb(0), 0);
    chk("R2 wrap ttype", ht(0), 8'h02);
    drain();
  endtask

  task automatic t_evid();
    pulse_ecr();
    accept(8'h10); accept(8'h20); accept(8'h30);
    for (int k = 0; k < 3; k++) begin
      chk("R4 R5 event order", he(2), k);
      chk("R5 ttype order", ht(2), 8'h10 * (k + 1));
      pop_lane(2, hb(2));
    end
    chk("R5 lane 2 emptied", rec_valid[2], 0);
    chk("R5 other lane untouched", he(5), 0);
    drain();
    ecr = 1'b1; l1a = 1'b1; ttype = 8'h33; tick();
    ecr = 1'b0; l1a = 1'b0;
    accept(8'h44);
    chk("R4 accept with reset carries 0", he(1), 0);
    pop_lane(1, hb(1));
    chk("R4 next accept carries 1", he(1), 1);
    drain();
  endtask

  task automatic t_mismatch();
    pulse_orbit();
    accept(8'h55);
    chk("R3 bcid at strobe", hb(3), 0);
    pop_lane(3, 12'd7);
    chk("R8 mismatch sets lane 3", err, 8'h08);
    wait_ticks(3);
    chk("R8 error sticky", err, 8'h08);
    pop_lane(4, 12'd0);
    chk("R8 match leaves lane 4 clear", err, 8'h08);
    err_clr = 8'h08; tick(); err_clr = '0;
    chk("R10 clear strobe", err, 0);
    drain();
  endtask

  task automatic t_empty();
    chk("R9 queue empty", rec_valid, 0);
    pop_lane(6, 12'd0);
    chk("R9 header on empty queue", err, 8'h40);
    hdr_valid[6] = 1'b1; err_clr[6] = 1'b1; tick();
    hdr_valid = '0; err_clr = '0;
    chk("R10 set wins over clear", err, 8'h40);
    err_clr[6] = 1'b1; tick(); err_clr = '0;
    chk("R10 clear after set", err, 0);
  endtask

  task automatic t_busy();
    for (int k = 0; k < DEPTH - 3; k++) accept(8'h66);
    chk("R6 three free not busy", busy, 0);
    accept(8'h67);
    chk("R6 two free busy", busy, 1);
    pop_lane(1, hb(1));
    chk("R6 one lane still at threshold", busy, 1);
    hdr_valid = 8'hFD; hdr_bcid = rec_bcid; tick(); hdr_valid = '0;
    chk("R6 all lanes three free", busy, 0);
    drain();
  endtask

  task automatic t_ovf();
    pulse_ecr();
    for (int k = 0; k < DEPTH; k++) accept(8'h70);
    chk("R6 full busy", busy, 1);
    chk("R7 no drop yet", ovf_cnt, 0);
    accept(8'h77);
    chk("R7 drop counted", ovf_cnt, 1);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R7 queue keeps only accepted", he(0), k);
      chk("R7 dropped type absent", ht(0), 8'h70);
      pop_lane(0, hb(0));
    end
    chk("R7 nothing extra queued", rec_valid[0], 0);
    drain();
    accept(8'h78);
    chk("R4 dropped accept advanced counter", he(0), DEPTH + 1);
    chk("R7 count holds", ovf_cnt, 1);
    drain();
    chk("final no errors flagged", err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bcid();
    t_wrap();
    t_evid();
    t_mismatch();
    t_empty();
    t_busy();
    t_ovf();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule